// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This unit produces a low-precision approximation of 1/sqrt(x) for a single-precision operand. A caller presents the operand with `in_valid` while `in_ready` is high. A mode bit sampled at the same edge selects an 8-bit or a 12-bit estimate. The result comes back as a one-cycle `out_valid` pulse together with the packed result word and an invalid-operation flag.

For a positive normal operand, the unit forms a scaled fixed-point value from the top fraction bits. The parity of the exponent decides how that value is scaled. The unit then preconditions the value into an integer `a` and searches for the largest integer `b` that keeps `a*b*b` under a mode-dependent power of two. The search takes one bit per cycle over a shared datapath. The estimate is `(b+1)/2`, packed under a halved, re-biased exponent. Zeros, infinities, NaNs and negative operands skip the search and return on the next cycle. Subnormal operands are treated as zero of the same sign. The unit holds one operand at a time: while a search runs, `in_ready` is low and the input is ignored.

Top module: `rsq_estimator`

## Requirements
- R1: After reset `out_valid`, `out_invalid` and `out_result` are 0 and `in_ready` is 1. From the edge that accepts a normal operand until its search completes, `in_ready` is 0 and any `in_valid` during that time is ignored.
- R2: Every accepted operand yields exactly one `out_valid` pulse. Special operands can be accepted on consecutive cycles, and each result appears on the cycle after its own accepting edge.
- R3: Count the accepting rising edge as edge 1. `out_valid` then rises right after edge 1 for a special operand, after edge 14 for a 12-bit search and after edge 10 for an 8-bit search.
- R4: The operand fields are sign = bit 31, exponent e = bits 30:23 and fraction f = bits 22:0. In 12-bit mode (`in_hi_prec`=1), an odd e gives the scaled value s = binary 01 followed by f[22:13]. An even e gives s = 1 followed by f[22:12].
- R5: In 8-bit mode (`in_hi_prec`=0), an odd e gives s = 01 followed by f[22:16], and an even e gives s = 1 followed by f[22:15].
- R6: If s is below 2048 (12-bit) or 256 (8-bit), then a = 2s+1. Otherwise a = 2*((s with bit 0 cleared)+1). Start b at 8192 (12-bit) or 512 (8-bit) and increment it while a*(b+1)^2 < 2^39 (12-bit) or 2^28 (8-bit). The estimate is (b+1)/2.
- R7: A 12-bit result for a positive normal operand has bit 31 = 0, bits 30:23 = floor((380-e)/2), bits 22:11 = the low 12 bits of the estimate, and bits 10:0 = 0.
- R8: An 8-bit result has the same sign and exponent as in R7, bits 22:15 = the low 8 bits of the estimate, and bits 14:0 = 0.
- R9: A negative operand that is not a NaN and has a nonzero exponent field (including negative infinity) returns 0x7FC00000 with `out_invalid`=1.
- R10: An operand with a zero exponent field (zero or subnormal, either sign) returns infinity of the operand's sign (0x7F800000 or 0xFF800000) with `out_invalid`=0.
- R11: Positive infinity (0x7F800000) returns 0x00000000 with `out_invalid`=0.
- R12: A NaN operand (exponent all ones, fraction nonzero, either sign) returns the operand with bit 22 set. `out_invalid` is 1 exactly when bit 22 of the operand was 0.
- R13: The operand and `in_hi_prec` are captured at the accepting edge. Changing either input afterwards does not alter that operand's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_hi_prec | input | 1 | 1 selects the 12-bit estimate, 0 the 8-bit estimate |
| in_operand | input | 32 | Single-precision operand |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_result | output | 32 | Result word |
| out_invalid | output | 1 | Invalid-operation flag for this result |

## Verification
Each operand is offered half a cycle before a rising edge. The bench then samples on every falling edge and records the first falling edge at which `out_valid` is high. That edge must be the first one for specials, the fourteenth for 12-bit searches and the tenth for 8-bit searches. Because sampling stays on falling edges, every register between acceptance and the output has settled. The bench keeps sampling for a fixed window after each operand, so a missing or repeated pulse is counted as an error. While a search runs, it drives changed operands and a flipped mode bit, then compares the result against a software loop that increments b one step at a time.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   // Operand classes; only CLS_NORMAL enters the iterative search.
   typedef enum logic [2:0] {
      CLS_NORMAL = 3'd0,
      CLS_QNAN   = 3'd1,
      CLS_SNAN   = 3'd2,
      CLS_NEG    = 3'd3,
      CLS_ZERO   = 3'd4,
      CLS_PINF   = 3'd5
   } rsq_class_e;

endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
   import rsq_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] opnd,
   output rsq_class_e           cls,
   output logic [EXP_W+MAN_W:0] special_word,
   output logic                 special_inv
);
   localparam int W = EXP_W + MAN_W + 1;

   logic             sgn;
   logic [EXP_W-1:0] expf;
   logic [MAN_W-1:0] man;
   logic             exp_ones;
   logic             exp_none;

   assign sgn      = opnd[W-1];
   assign expf     = opnd[W-2:MAN_W];
   assign man      = opnd[MAN_W-1:0];
   assign exp_ones = &expf;
   assign exp_none = ~|expf;

   // R12 before R10, R10 before R9, R9 before R11.
   always_comb begin
      cls          = CLS_NORMAL;
      special_word = '0;
      special_inv  = 1'b0;
      if (exp_ones && (man != '0)) begin
         cls          = man[MAN_W-1] ? CLS_QNAN : CLS_SNAN;
         special_word = opnd | (W'(1) << (MAN_W - 1));
         special_inv  = ~man[MAN_W-1];
      end else if (exp_none) begin
         cls          = CLS_ZERO;
         special_word = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      end else if (sgn) begin
         cls          = CLS_NEG;
         special_word = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
         special_inv  = 1'b1;
      end else if (exp_ones) begin
         cls          = CLS_PINF;
      end
   end

endmodule

// File: rtl/rsq_precond.sv
module rsq_precond #(
   parameter int EXP_W = 8,
   parameter int LO_W  = 8,
   parameter int HI_W  = 12,
   localparam int A_W  = HI_W + 1
) (
   input  logic             hi,
   input  logic [EXP_W-1:0] expf,
   input  logic [HI_W-2:0]  man_top,
   output logic [A_W-1:0]   a_val,
   output logic [EXP_W-1:0] res_exp
);
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam int OUT_K = 3 * BIAS - 1;

   logic [HI_W-1:0]  s_hi;
   logic [LO_W:0]    s_lo;
   logic [A_W-1:0]   a_hi;
   logic [LO_W+1:0]  a_lo;
   logic [EXP_W+1:0] diff;

   // R4 / R5: exponent parity decides the scaling of the fraction.
   always_comb begin
      if (expf[0]) begin
         s_hi = {2'b01, man_top[HI_W-2:1]};
         s_lo = {2'b01, man_top[HI_W-2 -: LO_W-1]};
      end else begin
         s_hi = {1'b1, man_top};
         s_lo = {1'b1, man_top[HI_W-2 -: LO_W]};
      end
   end

   // R6: lower half -> 2s+1; upper half -> 2*(even(s)+1).
   assign a_hi  = s_hi[HI_W-1] ? {s_hi[HI_W-1:1], 2'b10} : {s_hi, 1'b1};
   assign a_lo  = s_lo[LO_W]   ? {s_lo[LO_W:1], 2'b10}   : {s_lo, 1'b1};
   assign a_val = hi ? a_hi : A_W'(a_lo);

   // R7: halved, re-biased exponent.
   assign diff    = (EXP_W+2)'(OUT_K) - (EXP_W+2)'(expf);
   assign res_exp = EXP_W'(diff >> 1);

endmodule

// File: rtl/rsq_search.sv
module rsq_search #(
   parameter int LO_W = 8,
   parameter int HI_W = 12,
   localparam int A_W = HI_W + 1,
   localparam int K_W = HI_W + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           hi_in,
   input  logic [A_W-1:0] a_in,
   output logic           busy,
   output logic           fin,
   output logic           hi_q,
   output logic [K_W-1:0] root_nx
);
   localparam int B_W    = HI_W + 2;
   localparam int PROD_W = A_W + 2 * B_W;
   localparam int K_LO   = LO_W + 1;
   localparam int T_HI   = 3 * HI_W + 3;
   localparam int T_LO   = 3 * LO_W + 4;
   localparam logic [B_W-1:0]    BASE_HI = B_W'(1) << (HI_W + 1);
   localparam logic [B_W-1:0]    BASE_LO = B_W'(1) << (LO_W + 1);
   localparam logic [PROD_W-1:0] THR_HI  = PROD_W'(1) << T_HI;
   localparam logic [PROD_W-1:0] THR_LO  = PROD_W'(1) << T_LO;

   logic [A_W-1:0]    a_q;
   logic [K_W-1:0]    root_q;
   logic [K_W-1:0]    probe_q;
   logic              busy_q;
   logic [K_W-1:0]    trial;
   logic [B_W-1:0]    b_try;
   logic [2*B_W-1:0]  b_sq;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] thr;
   logic              fits;

   // R6: greedy bit-serial search, monotonic condition a*b*b < thr.
   assign trial   = root_q | probe_q;
   assign b_try   = (hi_q ? BASE_HI : BASE_LO) | B_W'(trial);
   assign b_sq    = {{B_W{1'b0}}, b_try} * {{B_W{1'b0}}, b_try};
   assign prod    = PROD_W'(a_q) * PROD_W'(b_sq);
   assign thr     = hi_q ? THR_HI : THR_LO;
   assign fits    = prod < thr;
   assign root_nx = fits ? trial : root_q;
   assign fin     = busy_q & probe_q[0];
   assign busy    = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q     <= '0;
         hi_q    <= 1'b0;
         root_q  <= '0;
         probe_q <= '0;
         busy_q  <= 1'b0;
      end else if (start) begin
         a_q     <= a_in;
         hi_q    <= hi_in;
         root_q  <= '0;
         probe_q <= hi_in ? (K_W'(1) << (K_W - 1)) : (K_W'(1) << (K_LO - 1));
         busy_q  <= 1'b1;
      end else if (busy_q) begin
         root_q  <= root_nx;
         probe_q <= probe_q >> 1;
         if (probe_q[0]) busy_q <= 1'b0;
      end
   end

   // Independent recomputation of the condition on the final root.
   logic [B_W-1:0]    b_fin;
   logic [2*B_W-1:0]  sq_fin;
   logic [PROD_W-1:0] prod_fin;
   assign b_fin    = (hi_q ? BASE_HI : BASE_LO) | B_W'(root_nx);
   assign sq_fin   = {{B_W{1'b0}}, b_fin} * {{B_W{1'b0}}, b_fin};
   assign prod_fin = PROD_W'(a_q) * PROD_W'(sq_fin);

   // R6
   fits_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> ((root_nx == '0) || (prod_fin < thr)));

   // R13
   search_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin) |=> (busy_q && $stable(a_q) && $stable(hi_q)));

endmodule

// File: rtl/rsq_pack.sv
module rsq_pack #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int LO_W  = 8,
   parameter int HI_W  = 12,
   localparam int K_W  = HI_W + 1
) (
   input  logic                 hi,
   input  logic [EXP_W-1:0]     res_exp,
   input  logic [K_W-1:0]       root,
   output logic [EXP_W+MAN_W:0] word
);
   localparam int B_W = HI_W + 2;
   localparam logic [B_W-1:0] BASE_HI = B_W'(1) << (HI_W + 1);
   localparam logic [B_W-1:0] BASE_LO = B_W'(1) << (LO_W + 1);

   logic [B_W-1:0] b_val;
   logic [B_W:0]   est;

   assign b_val = (hi ? BASE_HI : BASE_LO) | B_W'(root);
   assign est   = ({1'b0, b_val} + (B_W+1)'(1)) >> 1;

   // R7 / R8
   always_comb begin
      if (hi) word = {1'b0, res_exp, HI_W'(est), {(MAN_W-HI_W){1'b0}}};
      else    word = {1'b0, res_exp, LO_W'(est), {(MAN_W-LO_W){1'b0}}};
   end

endmodule

// File: rtl/rsq_estimator.sv
module rsq_estimator
   import rsq_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int LO_W  = 8,
   parameter int HI_W  = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 in_hi_prec,
   input  logic [EXP_W+MAN_W:0] in_operand,
   output logic                 out_valid,
   output logic [EXP_W+MAN_W:0] out_result,
   output logic                 out_invalid
);
   localparam int W   = EXP_W + MAN_W + 1;
   localparam int A_W = HI_W + 1;
   localparam int K_W = HI_W + 1;

   generate
      if (HI_W <= LO_W) begin : g_bad_order
         $error("HI_W must exceed LO_W");
      end
      if (HI_W + 1 > MAN_W) begin : g_bad_man
         $error("HI_W too wide for the fraction field");
      end
      if (LO_W < 2) begin : g_bad_lo
         $error("LO_W must be at least 2");
      end
      if (EXP_W < 3) begin : g_bad_exp
         $error("EXP_W must be at least 3");
      end
   endgenerate

   rsq_class_e       cls;
   logic [W-1:0]     special_word;
   logic             special_inv;
   logic [A_W-1:0]   a_val;
   logic [EXP_W-1:0] res_exp;
   logic [EXP_W-1:0] exp_q;
   logic             accept;
   logic             go_search;
   logic             srch_busy;
   logic             srch_fin;
   logic             srch_hi;
   logic [K_W-1:0]   root_nx;
   logic [W-1:0]     packed_word;
   logic             vld_q;
   logic [W-1:0]     res_q;
   logic             inv_q;

   rsq_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
      .opnd         (in_operand),
      .cls          (cls),
      .special_word (special_word),
      .special_inv  (special_inv)
   );

   rsq_precond #(.EXP_W(EXP_W), .LO_W(LO_W), .HI_W(HI_W)) u_precond (
      .hi      (in_hi_prec),
      .expf    (in_operand[W-2:MAN_W]),
      .man_top (in_operand[MAN_W-1 -: HI_W-1]),
      .a_val   (a_val),
      .res_exp (res_exp)
   );

   rsq_search #(.LO_W(LO_W), .HI_W(HI_W)) u_search (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (go_search),
      .hi_in   (in_hi_prec),
      .a_in    (a_val),
      .busy    (srch_busy),
      .fin     (srch_fin),
      .hi_q    (srch_hi),
      .root_nx (root_nx)
   );

   rsq_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .LO_W(LO_W), .HI_W(HI_W)) u_pack (
      .hi      (srch_hi),
      .res_exp (exp_q),
      .root    (root_nx),
      .word    (packed_word)
   );

   // R1: one operand in flight.
   assign in_ready  = ~srch_busy;
   assign accept    = in_valid & in_ready;
   assign go_search = accept & (cls == CLS_NORMAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         res_q <= '0;
         inv_q <= 1'b0;
         exp_q <= '0;
      end else begin
         vld_q <= 1'b0;
         if (accept && (cls != CLS_NORMAL)) begin
            vld_q <= 1'b1;
            res_q <= special_word;
            inv_q <= special_inv;
         end else if (srch_fin) begin
            vld_q <= 1'b1;
            res_q <= packed_word;
            inv_q <= 1'b0;
         end
         if (go_search) exp_q <= res_exp;
      end
   end

   assign out_valid   = vld_q;
   assign out_result  = res_q;
   assign out_invalid = inv_q;

   // R2
   accept_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid || srch_busy));

   // R2
   mid_search_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_busy && !srch_fin) |=> !out_valid);

   // R9
   invalid_is_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> (&out_result[W-2:MAN_W-1]));

endmodule

// File: tb/rsq_estimator_tb.sv
`timescale 1ns/1ps
module rsq_estimator_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        in_hi_prec = 1'b0;
   logic [31:0] in_operand = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_invalid;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   rsq_estimator u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_hi_prec  (in_hi_prec),
      .in_operand  (in_operand),
      .out_valid   (out_valid),
      .out_result  (out_result),
      .out_invalid (out_invalid)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit is_special(input logic [31:0] x);
      return (x[30:23] == 8'h00) || (x[30:23] == 8'hFF) || x[31];
   endfunction

   // Returns {invalid, word}, built from the requirement text.
   function automatic logic [32:0] ref_rsq(input logic [31:0] x, input bit hi);
      longint s, a, b, lim, half;
      int e, ex, est;
      e = int'(x[30:23]);
      if (e == 255 && x[22:0] != 0) return {~x[22], x | 32'h0040_0000};  // R12
      if (e == 0) return {1'b0, x[31], 8'hFF, 23'h0};                     // R10
      if (x[31]) return {1'b1, 32'h7FC0_0000};                            // R9
      if (e == 255) return {1'b0, 32'h0};                                 // R11
      if (hi) s = x[23] ? (1024 + longint'(x[22:13])) : (2048 + longint'(x[22:12]));
      else    s = x[23] ? (128 + longint'(x[22:16]))  : (256 + longint'(x[22:15]));
      half = hi ? 2048 : 256;
      if (s < half) a = 2 * s + 1;
      else a = (((s >> 1) << 1) + 1) * 2;
      b   = hi ? 8192 : 512;
      lim = hi ? (64'd1 << 39) : (64'd1 << 28);
      while (a * (b + 1) * (b + 1) < lim) b++;
      est = int'((b + 1) / 2);
      ex  = (380 - e) / 2;
      if (hi) return {1'b0, 1'b0, 8'(ex), 12'(est), 11'h0};
      else    return {1'b0, 1'b0, 8'(ex), 8'(est), 15'h0};
   endfunction

   // Offer one operand, optionally disturb the inputs while it is searched,
   // and watch a fixed window for its single result pulse.
   task automatic run_op(input logic [31:0] x, input bit hi, input string req, input bit noise);
      logic [32:0] ev;
      int want, first, pulses;
      logic [31:0] got_w;
      logic got_i;
      ev = ref_rsq(x, hi);
      want = is_special(x) ? 1 : (hi ? 14 : 10);
      first = -1; pulses = 0; got_w = '0; got_i = 1'b0;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1", "ready before offer", 64'(in_ready), 64'd1);
      in_valid = 1'b1; in_operand = x; in_hi_prec = hi;
      for (int c = 1; c <= 24; c++) begin
         @(negedge clk);
         if (c == 1) begin
            in_valid   = noise;
            in_operand = ~x;
            in_hi_prec = ~hi;
            if (!is_special(x))
               chk(in_ready == 1'b0, "R1", "ready during search", 64'(in_ready), 64'd0);
         end
         if (c == 8) in_valid = 1'b0;
         if (out_valid) begin
            pulses++;
            if (first < 0) begin
               first = c; got_w = out_result; got_i = out_invalid;
            end
         end
      end
      chk(first == want, "R3", "latency", 64'(first), 64'(want));
      chk(pulses == 1, "R2", "pulse count", 64'(pulses), 64'd1);
      chk(got_w == ev[31:0], req, $sformatf("result for %h", x), 64'(got_w), 64'(ev[31:0]));
      chk(got_i == ev[32], req, $sformatf("invalid for %h", x), 64'(got_i), 64'(ev[32]));
   endtask

   task automatic t_reset();
      chk(out_valid == 1'b0, "R1", "reset valid", 64'(out_valid), 64'd0);
      chk(out_invalid == 1'b0, "R1", "reset invalid", 64'(out_invalid), 64'd0);
      chk(out_result == 32'h0, "R1", "reset result", 64'(out_result), 64'd0);
      chk(in_ready == 1'b1, "R1", "reset ready", 64'(in_ready), 64'd1);
   endtask

   task automatic t_unit_values();
      run_op(32'h3F80_0000, 1'b1, "R4 R7", 1'b0);   // 1.0, odd exponent
      run_op(32'h4000_0000, 1'b1, "R4 R7", 1'b0);   // 2.0, even exponent
      run_op(32'h3F80_0000, 1'b0, "R5 R8", 1'b0);
      run_op(32'h4000_0000, 1'b0, "R5 R8", 1'b0);
      run_op(32'h4080_0000, 1'b1, "R6 R7", 1'b0);   // 4.0
      run_op(32'h3E80_0000, 1'b0, "R6 R8", 1'b0);   // 0.25
   endtask

   task automatic t_sweep();
      logic [22:0] fr [4] = '{23'h7F_FFFF, 23'h40_0000, 23'h15_5555, 23'h2A_AAAA};
      logic [7:0]  ex [4] = '{8'd1, 8'd254, 8'd127, 8'd128};
      for (int i = 0; i < 4; i++) begin
         run_op({1'b0, ex[i], fr[i]}, 1'b1, "R6 R7", 1'b0);
         run_op({1'b0, ex[(i+1)%4], fr[i]}, 1'b0, "R6 R8", 1'b0);
      end
   endtask

   task automatic t_mode_latch();
      run_op(32'h3FC0_1234, 1'b1, "R13", 1'b1);
      run_op(32'h4123_4567, 1'b0, "R13", 1'b1);
   endtask

   task automatic t_specials();
      run_op(32'hBF80_0000, 1'b1, "R9", 1'b0);    // -1.0
      run_op(32'hFF80_0000, 1'b0, "R9", 1'b0);    // -inf
      run_op(32'h0000_0000, 1'b1, "R10", 1'b0);   // +0
      run_op(32'h8000_0000, 1'b0, "R10", 1'b0);   // -0
      run_op(32'h0012_3456, 1'b1, "R10", 1'b0);   // +subnormal
      run_op(32'h8000_0001, 1'b1, "R10", 1'b0);   // -subnormal
      run_op(32'h7F80_0000, 1'b1, "R11", 1'b0);   // +inf
      run_op(32'h7FC0_0001, 1'b1, "R12", 1'b0);   // quiet NaN
      run_op(32'h7F80_0005, 1'b0, "R12", 1'b0);   // signalling NaN
      run_op(32'hFFA0_0000, 1'b1, "R12", 1'b0);   // negative signalling NaN
   endtask

   task automatic t_back_to_back();
      logic [31:0] ops [3] = '{32'hBF80_0000, 32'h7F80_0000, 32'h7F80_0001};
      logic [32:0] ev;
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1; in_operand = ops[i]; in_hi_prec = 1'b1;
         @(negedge clk);
         chk(in_ready == 1'b1, "R2", "ready between specials", 64'(in_ready), 64'd1);
         ev = ref_rsq(ops[i], 1'b1);
         chk(out_valid == 1'b1, "R2", "stream valid", 64'(out_valid), 64'd1);
         chk(out_result == ev[31:0], "R2", "stream result", 64'(out_result), 64'(ev[31:0]));
         chk(out_invalid == ev[32], "R2", "stream invalid", 64'(out_invalid), 64'(ev[32]));
      end
      in_valid = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R2", "stream end", 64'(out_valid), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unit_values();
      t_sweep();
      t_mode_latch();
      t_specials();
      t_back_to_back();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule